// File: doc/BRIEF.md
# Debug Byte FIFO Register Bridge

This block connects a 32-bit memory-mapped bus to a pair of byte-wide queues for a debug link. One queue holds bytes that a host sends toward the console and the bus reads them out. The other queue holds bytes the console writes over the bus, and the host drains them. The bus side is a small window of word registers. The host side is a plain one-byte-per-cycle push port and pop port.

The bus master may prefetch the word that follows the one it is reading. A prefetch must not consume a byte. For this reason the receive data register is visible at two adjacent word addresses. A read at the lower address removes the head byte from the queue. A read at the upper address only shows that byte. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. It then holds until the next read.

Top module: `dbg_fifo_bridge`

## Requirements
- R1: A read at word offset 0x08 returns the receive head byte in `bus_rdata[7:0]`, with bits 31:8 zero, in the cycle after the strobe. The read also removes that byte from the receive queue.
- R2: A read at offset 0x0C returns the same head byte as offset 0x08 but leaves the receive queue unchanged. Repeated reads there keep returning the same byte.
- R3: A write at offset 0x10 appends `bus_wdata[7:0]` to the transmit queue. The upper written bits are discarded, and the bytes leave the queue in the order they were written.
- R4: A read at offset 0x14 returns status. Bit 0 is 1 when the receive queue holds data, bit 1 is 1 when the transmit queue has room, and all other bits are zero.
- R5: A write at offset 0x14 empties the receive queue when bit 0 is set and the transmit queue when bit 1 is set, in one cycle. A clear that coincides with a push into the same queue wins.
- R6: A receive read at offset 0x08 or 0x0C while the receive queue is empty returns zero. It does not disturb the queue, so a byte pushed afterwards is the next one read.
- R7: A transmit write while the transmit queue holds DEPTH (16) bytes is dropped, and the bytes already queued are kept intact.
- R8: Writes to offsets 0x08 and 0x0C have no effect. Reads at offset 0x10, at unmapped offsets and at addresses that are not word aligned return zero. Writes to those addresses are ignored.
- R9: The host receive push stores `host_rx_data` once per cycle. `host_rx_full` is high when 16 bytes are held, and a push while it is high is dropped.
- R10: `host_tx_valid` is high while the transmit queue holds data, and `host_tx_data` shows its head byte. A pop removes one byte per cycle and is ignored when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address within the register window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| host_rx_push | input | 1 | Host pushes one byte into the receive queue |
| host_rx_data | input | 8 | Byte pushed by the host |
| host_rx_full | output | 1 | Receive queue is full |
| host_tx_pop | input | 1 | Host takes the transmit head byte |
| host_tx_data | output | 8 | Transmit head byte |
| host_tx_valid | output | 1 | Transmit queue holds data |

## Verification
The receive path is tested with alternating reads at the popping and the peeking address. A correct design returns a repeated byte after a peek and the next byte after a pop, so an aliasing mistake in either direction shows up as a wrong value. Reads of an empty queue, followed by a fresh push, test that an empty read neither moves the pointer nor returns stale data. Both queues are filled past capacity to test that overflowing bytes are dropped and do not overwrite queued ones. Clears are tested one queue at a time and also in the same cycle as a host push, which shows whether the clear is selective and whether it takes precedence.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
  // Word offsets inside the bridge window; software depends on these.
  localparam int unsigned OFS_RX_POP  = 32'h08;
  localparam int unsigned OFS_RX_PEEK = 32'h0C;
  localparam int unsigned OFS_TX      = 32'h10;
  localparam int unsigned OFS_STAT    = 32'h14;

  // Status / clear bit positions
  localparam int unsigned BIT_RX = 0;
  localparam int unsigned BIT_TX = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_POP,
    SEL_RX_PEEK,
    SEL_TX,
    SEL_STAT
  } reg_sel_t;
endpackage

// File: rtl/dbgf_byte_fifo.sv
module dbgf_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic              push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rptr];

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dbgf_decode.sv
module dbgf_decode
  import dbgf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output reg_sel_t          rsel,
  output reg_sel_t          wsel
);
  reg_sel_t hit;

  always_comb begin
    hit = SEL_NONE;
    if      (addr == ADDR_W'(OFS_RX_POP))  hit = SEL_RX_POP;
    else if (addr == ADDR_W'(OFS_RX_PEEK)) hit = SEL_RX_PEEK;
    else if (addr == ADDR_W'(OFS_TX))      hit = SEL_TX;
    else if (addr == ADDR_W'(OFS_STAT))    hit = SEL_STAT;
  end

  // Receive addresses are read-only; the transmit address is write-only.
  always_comb begin
    rsel = SEL_NONE;
    wsel = SEL_NONE;
    if (rd && hit != SEL_TX) rsel = hit;
    if (wr && (hit == SEL_TX || hit == SEL_STAT)) wsel = hit;
  end
endmodule

// File: rtl/dbg_fifo_bridge.sv
module dbg_fifo_bridge
  import dbgf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              host_rx_push,
  input  logic [7:0]        host_rx_data,
  output logic              host_rx_full,
  input  logic              host_tx_pop,
  output logic [7:0]        host_tx_data,
  output logic              host_tx_valid
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  reg_sel_t         rsel, wsel;
  logic [7:0]       rx_head, tx_head;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             rx_flush, tx_flush;

  dbgf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .rsel (rsel),
    .wsel (wsel)
  );

  assign rx_flush = (wsel == SEL_STAT) && bus_wdata[BIT_RX];
  assign tx_flush = (wsel == SEL_STAT) && bus_wdata[BIT_TX];

  dbgf_byte_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .flush     (rx_flush),
    .push      (host_rx_push),
    .push_data (host_rx_data),
    .pop       (rsel == SEL_RX_POP),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  dbgf_byte_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .flush     (tx_flush),
    .push      (wsel == SEL_TX),
    .push_data (bus_wdata[7:0]),
    .pop       (host_tx_pop),
    .head      (tx_head),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (rsel)
        SEL_RX_POP,
        SEL_RX_PEEK: bus_rdata <= rx_empty ? 32'd0 : {24'd0, rx_head};
        SEL_STAT: begin
          bus_rdata         <= '0;
          bus_rdata[BIT_RX] <= !rx_empty;
          bus_rdata[BIT_TX] <= !tx_full;
        end
        default:     bus_rdata <= '0;
      endcase
    end
  end

  assign host_rx_full  = rx_full;
  assign host_tx_data  = tx_head;
  assign host_tx_valid = !tx_empty;
endmodule

// File: rtl/dbgf_checker.sv
module dbgf_checker #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic [31:0]                bus_wdata,
  input logic [31:0]                bus_rdata,
  input logic                       host_rx_push,
  input logic                       host_tx_pop,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic [$clog2(DEPTH+1)-1:0] tx_count
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic at_pop, at_peek, at_stat;
  assign at_pop  = bus_addr == ADDR_W'(dbgf_pkg::OFS_RX_POP);
  assign at_peek = bus_addr == ADDR_W'(dbgf_pkg::OFS_RX_PEEK);
  assign at_stat = bus_addr == ADDR_W'(dbgf_pkg::OFS_STAT);

  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_pop && rx_count != '0 && !host_rx_push && !bus_wr
    |=> rx_count == $past(rx_count) - 1'b1); // R1

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_peek && !host_rx_push && !bus_wr
    |=> rx_count == $past(rx_count)); // R2

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd) && $past(at_pop || at_peek) |-> bus_rdata[31:8] == 24'd0); // R1

  AST_CLEAR_RX: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_stat && bus_wdata[0] |=> rx_count == '0); // R5

  AST_EMPTY_READ_SAFE: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_pop && rx_count == '0 && !host_rx_push
    |=> rx_count == '0 && bus_rdata == 32'd0); // R6

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    tx_count == CNT_W'(DEPTH) && !host_tx_pop && !(bus_wr && at_stat)
    |=> tx_count == CNT_W'(DEPTH)); // R7

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_count <= CNT_W'(DEPTH)); // R9
endmodule

bind dbg_fifo_bridge dbgf_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .host_rx_push (host_rx_push),
  .host_tx_pop  (host_tx_pop),
  .rx_count     (rx_count),
  .tx_count     (tx_count)
);

// File: tb/dbg_fifo_bridge_test.sv
module dbg_fifo_bridge_test;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 16;
  localparam logic [1:0] OP_PUSH = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2, OP_POP = 2'd3;
  localparam int NV = 19;

  // {op, addr, data, expected}
  localparam logic [73:0] VEC [NV] = '{
    {OP_RD,   8'h14, 32'h0,         32'h2},   // R4 idle status
    {OP_PUSH, 8'h00, 32'hA5,        32'h0},
    {OP_PUSH, 8'h00, 32'h3C,        32'h0},
    {OP_RD,   8'h0C, 32'h0,         32'hA5},  // R2 peek
    {OP_RD,   8'h0C, 32'h0,         32'hA5},  // R2 peek again, same byte
    {OP_RD,   8'h08, 32'h0,         32'hA5},  // R1 pop
    {OP_RD,   8'h14, 32'h0,         32'h3},   // R4 rx has data
    {OP_RD,   8'h08, 32'h0,         32'h3C},  // R1 pop
    {OP_RD,   8'h08, 32'h0,         32'h0},   // R6 empty read
    {OP_RD,   8'h0C, 32'h0,         32'h0},   // R6 empty peek
    {OP_PUSH, 8'h00, 32'h77,        32'h0},
    {OP_RD,   8'h08, 32'h0,         32'h77},  // R6 pointer intact
    {OP_WR,   8'h10, 32'hFFFFFF11,  32'h0},   // R3
    {OP_WR,   8'h10, 32'h22,        32'h0},   // R3
    {OP_WR,   8'h08, 32'h99,        32'h0},   // R8 ignored
    {OP_RD,   8'h10, 32'h0,         32'h0},   // R8 tx reads zero
    {OP_RD,   8'h0A, 32'h0,         32'h0},   // R8 unaligned
    {OP_POP,  8'h00, 32'h0,         32'h11},  // R10 / R3 order
    {OP_POP,  8'h00, 32'h0,         32'h22}   // R10
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              host_rx_push = 1'b0;
  logic [7:0]        host_rx_data = '0;
  logic              host_rx_full;
  logic              host_tx_pop = 1'b0;
  logic [7:0]        host_tx_data;
  logic              host_tx_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dbg_fifo_bridge #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (
    .clk, .rst, .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata,
    .host_rx_push, .host_rx_data, .host_rx_full,
    .host_tx_pop, .host_tx_data, .host_tx_valid
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_push(input logic [7:0] b);
    @(negedge clk); host_rx_push = 1'b1; host_rx_data = b;
    @(negedge clk); host_rx_push = 1'b0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; r = bus_rdata;
  endtask

  task automatic host_pop(output logic [7:0] b, output logic v);
    @(negedge clk); b = host_tx_data; v = host_tx_valid; host_tx_pop = 1'b1;
    @(negedge clk); host_tx_pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    logic        v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("reset rdata", bus_rdata, 32'h0);
    check("reset R9 full", {31'd0, host_rx_full}, 32'h0);
    check("reset R10 valid", {31'd0, host_tx_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        OP_PUSH: host_push(d[7:0]);
        OP_WR:   bus_write(a, d);
        OP_RD: begin
          bus_read(a, r);
          check($sformatf("vector %0d (R1 R2 R4 R6 R8)", i), r, e);
        end
        default: begin
          host_pop(b, v);
          check($sformatf("vector %0d R10 data", i), {24'd0, b}, e);
          check($sformatf("vector %0d R10 valid", i), {31'd0, v}, 32'h1);
        end
      endcase
    end
    @(negedge clk);
    check("R10 drained", {31'd0, host_tx_valid}, 32'h0);
    bus_read(8'h14, r);
    check("R8 write to rx ignored", r, 32'h2);

    // R8: unaligned write near tx register is ignored
    bus_write(8'h12, 32'h55);
    @(negedge clk);
    check("R8 unaligned write", {31'd0, host_tx_valid}, 32'h0);

    // R9: fill receive queue, overflow dropped
    for (int i = 0; i < DEPTH; i++) host_push(8'h40 + 8'(i));
    check("R9 full flag", {31'd0, host_rx_full}, 32'h1);
    host_push(8'hEE);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(8'h08, r);
      check("R9 order", r, 32'h40 + i);
    end
    bus_read(8'h14, r);
    check("R9 empty after drain", r, 32'h2);

    // R7: transmit overflow dropped, oldest kept
    for (int i = 0; i <= DEPTH; i++) bus_write(8'h10, 32'h80 + i);
    bus_read(8'h14, r);
    check("R7 tx full status", r, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      host_pop(b, v);
      check("R7 tx order", {23'd0, v, b}, 32'h180 + i);
    end
    @(negedge clk);
    check("R7 no extra byte", {31'd0, host_tx_valid}, 32'h0);
    host_pop(b, v);
    check("R10 pop when empty ignored", {31'd0, host_tx_valid}, 32'h0);

    // R5: selective clears
    host_push(8'h01); host_push(8'h02);
    bus_write(8'h10, 32'h33);
    bus_write(8'h14, 32'h1);
    bus_read(8'h14, r);
    check("R5 rx cleared only", r, 32'h2);
    check("R5 tx kept", {31'd0, host_tx_valid}, 32'h1);
    bus_write(8'h14, 32'h2);
    @(negedge clk);
    check("R5 tx cleared", {31'd0, host_tx_valid}, 32'h0);
    // R5: clear wins over a push in the same cycle
    @(negedge clk);
    host_rx_push = 1'b1; host_rx_data = 8'hAA;
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1;
    @(negedge clk);
    host_rx_push = 1'b0; bus_wr = 1'b0;
    bus_read(8'h14, r);
    check("R5 clear beats push", r, 32'h2);
    bus_read(8'h08, r);
    check("R5 no stale byte", r, 32'h0);

    finish_run();
  end
endmodule